// File: doc/BRIEF.md
# Control Word Integration Detector

The block steadies a slowly changing 16-bit control word and four per-channel chargeable flags that arrive once per frame over a noisy link. Each bit is voted on its own over a fixed window of frames, and the reported value changes only when the vote is clear. A clean reception is still reflected within one update period. The settled values are shown as three read bytes, drive several mute indications, and are marked by a one-cycle update strobe.

Upstream logic presents the control word and flags together with a single-cycle frame strobe and a sync-valid level. Frames are grouped into update periods of 18 strobes. Only the first 15 frames of a period take part in the vote, and frames received while out of sync are left out. On the last strobe of the period the block decides each bit and clears its tallies for the next period.

Top module: `cwi_integrator`

## Requirements
- R1: After reset, all three read bytes, `upd_stb` and every mute output are 0.
- R2: Frame strobes are grouped into periods of 18. The decided values appear together with a single-cycle `upd_stb` pulse on the cycle after the 18th strobe. Exactly one pulse occurs per period. Frames 16 to 18 of a period are not counted.
- R3: A bit becomes 1 when at least 12 of the frames counted in the period carried a 1 in that bit.
- R4: A bit becomes 0 when at least 12 of the frames counted in the period carried a 0 in that bit.
- R5: When neither count reaches 12, the bit keeps its previous decided value.
- R6: A frame whose strobe arrives with `sync_ok` low is not counted, neither as a 1 nor as a 0.
- R7: The tallies start from zero in every period, so no earlier period affects a decision.
- R8: The chargeable flags are voted the same way. `chg_rd` carries channel n's flag on bit n-1, and bits 7:4 read 0.
- R9: Control bit n (1 to 16) arrives on `ctrl_word[n-1]`. `ctrl_rd_lo` holds decided bits 1 to 8 on positions 0 to 7, and `ctrl_rd_hi` holds bits 9 to 16 on positions 0 to 7.
- R10: `mute_nonbcast` equals decided control bit 7, and `mute_suppress` equals decided control bit 16.
- R11: `mute_nonaudio` is 1 when decided control bits 2 and 3 are both 1, or when bits 4 and 5 are both 1.
- R12: `mute_chg[n-1]` equals the decided chargeable flag of channel n.
- R13: Between update pulses, all read bytes and mute outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| sync_ok | input | 1 | Frame sync is valid for this frame |
| ctrl_word | input | 16 | Raw control word of the frame |
| chg_flag | input | 4 | Raw chargeable flags, one per channel |
| ctrl_rd_lo | output | 8 | Decided control bits 1 to 8 |
| ctrl_rd_hi | output | 8 | Decided control bits 9 to 16 |
| chg_rd | output | 8 | Decided chargeable flags in the low nibble |
| upd_stb | output | 1 | Pulse marking a fresh decision |
| mute_nonbcast | output | 1 | Non-broadcast mute request |
| mute_suppress | output | 1 | Audio-suppression mute request |
| mute_nonaudio | output | 1 | Non-audio mute request |
| mute_chg | output | 4 | Per-channel chargeable mute request |

## Verification
The bench builds the block with its default parameters: a 15-frame window, an 18-frame period and a threshold of 12. With these values the boundary counts of 11 and 12 votes, the three ignored tail frames, and the loss of 3 or 4 frames to lost sync can all be reached within a single period. Mixed patterns, where agreeing bits decide while disagreeing bits hold, are applied to both the control word and the flags. Each mute decode is driven through its enabling bit pairs.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
   // 1-based control bit positions that the mute decode relies on
   localparam int unsigned CB_NONBCAST = 7;
   localparam int unsigned CB_SUPPRESS = 16;
   localparam int unsigned CB_NA_A0    = 2;
   localparam int unsigned CB_NA_A1    = 3;
   localparam int unsigned CB_NA_B0    = 4;
   localparam int unsigned CB_NA_B1    = 5;

   typedef enum logic [1:0] {
      VOTE_HOLD = 2'd0,
      VOTE_ONE  = 2'd1,
      VOTE_ZERO = 2'd2
   } vote_e;

   function automatic vote_e vote_decide(input logic [7:0] ones,
                                         input logic [7:0] valid,
                                         input logic [7:0] th);
      logic [7:0] zeros;
      zeros = valid - ones;
      if (ones >= th)       return VOTE_ONE;
      else if (zeros >= th) return VOTE_ZERO;
      else                  return VOTE_HOLD;
   endfunction
endpackage

// File: rtl/cwi_frame_seq.sv
module cwi_frame_seq #(
   parameter int unsigned WIN    = 15,
   parameter int unsigned PERIOD = 18,
   localparam int unsigned IDX_W = $clog2(PERIOD),
   localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb,
   input  logic             sync_ok,
   output logic             sample_en,
   output logic             close,
   output logic [CNT_W-1:0] valid_cnt,
   output logic             upd_stb
);
   logic [IDX_W-1:0] idx;

   assign sample_en = frame_stb && sync_ok && (int'(idx) < WIN);
   assign close     = frame_stb && (int'(idx) == PERIOD - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx       <= '0;
         valid_cnt <= '0;
         upd_stb   <= 1'b0;
      end else begin
         upd_stb <= close;
         if (frame_stb)
            idx <= close ? '0 : idx + 1'b1;
         if (close)
            valid_cnt <= '0;
         else if (sample_en)
            valid_cnt <= valid_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cwi_vote_cell.sv
module cwi_vote_cell #(
   parameter int unsigned WIN    = 15,
   parameter int unsigned ACC_TH = 12,
   localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic             close,
   input  logic             bit_in,
   input  logic [CNT_W-1:0] valid_cnt,
   output logic             bit_q
);
   import cwi_pkg::*;

   logic [CNT_W-1:0] ones;
   vote_e            verdict;

   assign verdict = vote_decide(8'(ones), 8'(valid_cnt), 8'(ACC_TH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones  <= '0;
         bit_q <= 1'b0;
      end else if (close) begin
         ones <= '0;
         case (verdict)
            VOTE_ONE:  bit_q <= 1'b1;
            VOTE_ZERO: bit_q <= 1'b0;
            default:   bit_q <= bit_q;
         endcase
      end else if (sample_en && bit_in) begin
         ones <= ones + 1'b1;
      end
   end
endmodule

// File: rtl/cwi_mute_map.sv
module cwi_mute_map #(
   parameter int unsigned CW_W = 16,
   parameter int unsigned CH_N = 4
) (
   input  logic [CW_W-1:0] ctrl_q,
   input  logic [CH_N-1:0] chg_q,
   output logic            mute_nonbcast,
   output logic            mute_suppress,
   output logic            mute_nonaudio,
   output logic [CH_N-1:0] mute_chg
);
   import cwi_pkg::*;

   assign mute_nonbcast = ctrl_q[CB_NONBCAST-1];
   assign mute_suppress = ctrl_q[CB_SUPPRESS-1];
   assign mute_nonaudio = (ctrl_q[CB_NA_A0-1] & ctrl_q[CB_NA_A1-1]) |
                          (ctrl_q[CB_NA_B0-1] & ctrl_q[CB_NA_B1-1]);
   assign mute_chg      = chg_q;
endmodule

// File: rtl/cwi_integrator.sv
module cwi_integrator #(
   parameter int unsigned CW_W   = 16,
   parameter int unsigned CH_N   = 4,
   parameter int unsigned WIN    = 15,
   parameter int unsigned PERIOD = 18,
   parameter int unsigned ACC_TH = 12,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              sync_ok,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [CH_N-1:0]   chg_flag,
   output logic [BYTE_W-1:0] ctrl_rd_lo,
   output logic [BYTE_W-1:0] ctrl_rd_hi,
   output logic [BYTE_W-1:0] chg_rd,
   output logic              upd_stb,
   output logic              mute_nonbcast,
   output logic              mute_suppress,
   output logic              mute_nonaudio,
   output logic [CH_N-1:0]   mute_chg
);
   localparam int unsigned NB    = CW_W + CH_N;
   localparam int unsigned CNT_W = $clog2(WIN + 1);

   generate
      if (CW_W != 2 * BYTE_W)
         $error("control word must fill exactly two read bytes");
      if (CH_N > BYTE_W)
         $error("flag count exceeds one read byte");
      if (WIN > PERIOD)
         $error("vote window longer than update period");
      if (2 * ACC_TH <= WIN || ACC_TH > WIN)
         $error("threshold must be a strict majority within the window");
      if (CW_W < 16)
         $error("mute decode needs 16 control bits");
   endgenerate

   logic             sample_en;
   logic             close;
   logic [CNT_W-1:0] valid_cnt;
   logic [NB-1:0]    raw_vec;
   logic [NB-1:0]    dec_vec;

   assign raw_vec = {chg_flag, ctrl_word};

   cwi_frame_seq #(.WIN(WIN), .PERIOD(PERIOD)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .sync_ok   (sync_ok),
      .sample_en (sample_en),
      .close     (close),
      .valid_cnt (valid_cnt),
      .upd_stb   (upd_stb)
   );

   for (genvar g = 0; g < NB; g++) begin : g_cell
      cwi_vote_cell #(.WIN(WIN), .ACC_TH(ACC_TH)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .sample_en (sample_en),
         .close     (close),
         .bit_in    (raw_vec[g]),
         .valid_cnt (valid_cnt),
         .bit_q     (dec_vec[g])
      );
   end

   cwi_mute_map #(.CW_W(CW_W), .CH_N(CH_N)) u_mute (
      .ctrl_q        (dec_vec[CW_W-1:0]),
      .chg_q         (dec_vec[NB-1:CW_W]),
      .mute_nonbcast (mute_nonbcast),
      .mute_suppress (mute_suppress),
      .mute_nonaudio (mute_nonaudio),
      .mute_chg      (mute_chg)
   );

   assign ctrl_rd_lo = dec_vec[BYTE_W-1:0];
   assign ctrl_rd_hi = dec_vec[CW_W-1:BYTE_W];

   if (CH_N < BYTE_W) begin : g_pad
      assign chg_rd = {{(BYTE_W-CH_N){1'b0}}, dec_vec[NB-1:CW_W]};
   end else begin : g_full
      assign chg_rd = dec_vec[NB-1:CW_W];
   end
endmodule

// File: rtl/cwi_integrator_chk.sv
module cwi_integrator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_stb,
   input logic       upd_stb,
   input logic [7:0] ctrl_rd_lo,
   input logic [7:0] ctrl_rd_hi,
   input logic [7:0] chg_rd,
   input logic       mute_nonbcast,
   input logic       mute_nonaudio
);
   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb);

   assert_upd_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $past(frame_stb));

   assert_hold_between_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_stb |-> ($stable(ctrl_rd_lo) && $stable(ctrl_rd_hi) && $stable(chg_rd)));

   assert_nonbcast_on_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute_nonbcast) |-> upd_stb);

   assert_nonaudio_needs_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mute_nonaudio |-> ($countones(ctrl_rd_lo[4:1]) >= 2));
endmodule

bind cwi_integrator cwi_integrator_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_stb     (frame_stb),
   .upd_stb       (upd_stb),
   .ctrl_rd_lo    (ctrl_rd_lo),
   .ctrl_rd_hi    (ctrl_rd_hi),
   .chg_rd        (chg_rd),
   .mute_nonbcast (mute_nonbcast),
   .mute_nonaudio (mute_nonaudio)
);

// File: tb/cwi_integrator_bench.sv
module cwi_integrator_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;

   typedef struct packed {
      logic [15:0] a;
      logic [15:0] b;
      logic [4:0]  n_a;
      logic [4:0]  n_async;
      logic [3:0]  ca;
      logic [3:0]  cb;
      logic [15:0] exp_w;
      logic [3:0]  exp_c;
   } vec_t;

   // frames [0,n_async) out of sync with garbage, [n_async,n_a) carry a, [n_a,15) carry b
   localparam vec_t VEC [NVEC] = '{
      '{16'hA5C3, 16'h0000, 5'd15, 5'd0, 4'hA, 4'h0, 16'hA5C3, 4'hA}, // R3 full agreement
      '{16'h0000, 16'hFFFF, 5'd12, 5'd0, 4'h0, 4'hF, 16'h0000, 4'h0}, // R4 exactly 12 zeros
      '{16'hFFFF, 16'h0000, 5'd11, 5'd0, 4'hF, 4'h0, 16'h0000, 4'h0}, // R5 11 ones holds
      '{16'hFFFF, 16'h0000, 5'd12, 5'd0, 4'hF, 4'h0, 16'hFFFF, 4'hF}, // R3 exactly 12 ones
      '{16'h0000, 16'hFFFF, 5'd11, 5'd0, 4'h0, 4'hF, 16'hFFFF, 4'hF}, // R5 11 zeros holds
      '{16'h1234, 16'h0000, 5'd15, 5'd3, 4'h5, 4'h0, 16'h1234, 4'h5}, // R6 12 counted
      '{16'h0000, 16'h0000, 5'd15, 5'd4, 4'h0, 4'h0, 16'h1234, 4'h5}, // R6 only 11 counted
      '{16'h0006, 16'h0000, 5'd15, 5'd0, 4'h0, 4'h0, 16'h0006, 4'h0}, // R11 bits 2,3
      '{16'h8040, 16'h0000, 5'd15, 5'd0, 4'h4, 4'h0, 16'h8040, 4'h4}, // R10 bits 7,16
      '{16'h0018, 16'h0000, 5'd15, 5'd0, 4'h3, 4'h0, 16'h0018, 4'h3}, // R11 bits 4,5
      '{16'hFF00, 16'h0F0F, 5'd11, 5'd0, 4'hC, 4'hA, 16'h0F08, 4'hA}  // R5 mixed per bit
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       sync_ok = 1'b0;
   logic [15:0] ctrl_word = '0;
   logic [3:0]  chg_flag = '0;
   logic [7:0]  ctrl_rd_lo, ctrl_rd_hi, chg_rd;
   logic        upd_stb, mute_nonbcast, mute_suppress, mute_nonaudio;
   logic [3:0]  mute_chg;

   int checks = 0;
   int errors = 0;
   int upd_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwi_integrator u_cwi_integrator (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sync_ok(sync_ok),
      .ctrl_word(ctrl_word), .chg_flag(chg_flag),
      .ctrl_rd_lo(ctrl_rd_lo), .ctrl_rd_hi(ctrl_rd_hi), .chg_rd(chg_rd),
      .upd_stb(upd_stb), .mute_nonbcast(mute_nonbcast), .mute_suppress(mute_suppress),
      .mute_nonaudio(mute_nonaudio), .mute_chg(mute_chg)
   );

   always @(negedge clk) if (upd_stb) upd_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [15:0] w, input logic [3:0] c, input logic s);
      @(negedge clk);
      ctrl_word = w; chg_flag = c; sync_ok = s; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      ctrl_word = ~w; chg_flag = ~c;
      @(negedge clk);
   endtask

   task automatic check_outputs(input string tag, input logic [15:0] w, input logic [3:0] c);
      chk({tag, " R9 lo"}, 32'(ctrl_rd_lo), 32'(w[7:0]));
      chk({tag, " R9 hi"}, 32'(ctrl_rd_hi), 32'(w[15:8]));
      chk({tag, " R8 chg"}, 32'(chg_rd), 32'({4'h0, c}));
      chk({tag, " R10 nonbcast"}, 32'(mute_nonbcast), 32'(w[6]));
      chk({tag, " R10 suppress"}, 32'(mute_suppress), 32'(w[15]));
      chk({tag, " R11 nonaudio"}, 32'(mute_nonaudio), 32'((w[1] & w[2]) | (w[3] & w[4])));
      chk({tag, " R12 mute_chg"}, 32'(mute_chg), 32'(c));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] prev_w;
      logic [3:0]  prev_c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_outputs("R1 reset", 16'h0000, 4'h0);
      chk("R1 upd_stb", 32'(upd_stb), 32'd0);
      prev_w = '0; prev_c = '0;

      for (int v = 0; v < NVEC; v++) begin
         upd_cnt = 0;
         for (int f = 0; f < 18; f++) begin
            if (f < int'(VEC[v].n_async))
               send_frame(~VEC[v].a, ~VEC[v].ca, 1'b0);
            else if (f < int'(VEC[v].n_a))
               send_frame(VEC[v].a, VEC[v].ca, 1'b1);
            else if (f < 15)
               send_frame(VEC[v].b, VEC[v].cb, 1'b1);
            else
               send_frame(~VEC[v].a, ~VEC[v].ca, 1'b1); // R2 tail frames ignored
            if (f == 16) begin
               // R13: nothing moves before the period closes
               chk("R13 hold lo", 32'(ctrl_rd_lo), 32'(prev_w[7:0]));
               chk("R13 hold chg", 32'(chg_rd), 32'({4'h0, prev_c}));
               chk("R2 no early pulse", 32'(upd_cnt), 32'd0);
            end
         end
         repeat (2) @(negedge clk);
         chk("R2 one pulse", 32'(upd_cnt), 32'd1);
         check_outputs($sformatf("vec%0d R3 R4 R5 R7", v), VEC[v].exp_w, VEC[v].exp_c);
         prev_w = VEC[v].exp_w; prev_c = VEC[v].exp_c;
      end

      // R6: a whole period out of sync keeps every bit
      upd_cnt = 0;
      for (int f = 0; f < 18; f++) send_frame(16'h0000, 4'h0, 1'b0);
      repeat (2) @(negedge clk);
      chk("R6 all async pulse", 32'(upd_cnt), 32'd1);
      check_outputs("R6 all async hold", prev_w, prev_c);

      // R1: reset in mid operation clears everything
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_outputs("R1 mid reset", 16'h0000, 4'h0);
      chk("R1 mid reset upd", 32'(upd_stb), 32'd0);

      finish_run();
   end
endmodule